// File: doc/BRIEF.md
# Serial Word Shifter with Bit-Order Option

This block is a single-lane serial datapath with one transmit engine and one receive engine. Both run on the system clock. The bit clocks and frame syncs come from outside the block; it samples them, synchronises them and finds their edges itself. A word written into the transmit holding register is copied into a shift register when a frame sync rises. It then leaves on the transmit pin one bit per active bit-clock edge. Receive bits are shifted in from the receive pin. A finished word moves to a buffer register and then to a read register, where the host picks it up.

The receive word length and the transmit word length are chosen independently: 8, 12 or 16 bits. Words go MSB first unless a 2-bit order code selects LSB-first. LSB-first always moves 8-bit words, whatever length is set. Each direction has its own bit-clock polarity. An internal loopback feeds the transmit pin, bit clock and frame sync into the receiver, so a written word can be read back without any external wiring.

Each engine is a three-state machine. The states are IDLE, ARMED and SHIFT:
- IDLE to ARMED happens on a synchronised frame-sync rise.
- ARMED to SHIFT happens on the first active bit-clock edge, which moves bit 0 of the word.
- SHIFT to IDLE happens on the active edge that moves the last bit.
- Every other edge keeps the state.

Top module: `serial_word_shifter`

## Requirements
- R1: With order code 00, 10 or 11, every word is sent and received MSB first.
- R2: Length code 0 selects 8-bit words, 1 selects 12-bit words, and 2 or 3 select 16-bit words. Received words are placed right-justified in `rd_data`, and the unused upper bits read as zero.
- R3: Transmit order code 01 sends 8-bit words LSB first.
- R4: Receive order code 01 assembles 8-bit words that arrive LSB first.
- R5: While the order code of a direction is 01, that direction moves exactly 8 bits per word, whatever its length code.
- R6: Polarity 0 makes the rising edge active for transmit and the falling edge active for receive. Polarity 1 swaps the active edge in each direction.
- R7: A word starts on the first active edge after a frame-sync rise, and exactly one bit moves per active edge. Bit-clock edges seen in IDLE leave `tx_pin` unchanged. `tx_pin` resets to 0.
- R8: With `cfg_loop` high, the receiver takes its data from `tx_pin` and its bit clock and frame sync from `tx_bclk` and `tx_fs`. `rx_pin` is ignored in this mode.
- R9: A completed received word moves through the buffer to the read register. At that moment `rx_ready` rises and `rx_event` pulses for one cycle. `rd_data` stays stable until `rd_en` pops the word. `rx_ready` is 0 after reset.
- R10: `tx_ready` is high while the holding register is empty, including after reset. `tx_event` pulses once each time a written word leaves the holding register for the shift register.
- R11: If a frame starts while the holding register is empty, the previous word is sent again and `tx_underflow` is set. The next `wr_en` clears the flag.
- R12: If a word completes while both the buffer and the read register are occupied, that word is discarded and `rx_overrun` is set. A read clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_loop | input | 1 | Internal loopback enable |
| cfg_tx_pol | input | 1 | Transmit bit-clock polarity |
| cfg_tx_len | input | 2 | Transmit word-length code |
| cfg_tx_order | input | 2 | Transmit bit-order code (01 = LSB first) |
| cfg_rx_pol | input | 1 | Receive bit-clock polarity |
| cfg_rx_len | input | 2 | Receive word-length code |
| cfg_rx_order | input | 2 | Receive bit-order code (01 = LSB first) |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| tx_pin | output | 1 | Serial transmit data |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_pin | input | 1 | Serial receive data |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 16 | Word to transmit |
| tx_ready | output | 1 | Holding register empty |
| tx_event | output | 1 | One-cycle pulse when the holding register empties |
| tx_underflow | output | 1 | A frame started with no new word |
| rd_en | input | 1 | Pop the read register |
| rd_data | output | 16 | Received word, right-justified |
| rx_ready | output | 1 | Read register holds a word |
| rx_event | output | 1 | One-cycle pulse when a word reaches the read register |
| rx_overrun | output | 1 | A received word was discarded |

## Verification
The hardest state to reach from the ports is the one where the forced 8-bit length actually ends a word. Reading the first eight bits cannot tell an 8-bit frame from the start of a 16-bit frame. The stimulus therefore follows the forced frame at once with a second frame and a new word. An engine still inside a 16-bit word would ignore that frame sync and send the stale upper byte. The overrun case is also hard to reach: it needs two unread words parked in the buffer and the read register before a third word completes. The bench sends three frames with no read in between, then pops the two kept words in order.

// File: rtl/sws_pkg.sv
package sws_pkg;

    localparam int WORD_MAX = 16;
    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 2;
    localparam int CNT_W    = $clog2(WORD_MAX + 1);

    localparam logic [CODE_W-1:0] ORDER_LSB = 2'b01;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ARMED = 2'd1,
        ENG_SHIFT = 2'd2
    } eng_state_t;

    // bits per word for a length code and an order code
    function automatic logic [CNT_W-1:0] word_bits(input logic [CODE_W-1:0] len_code,
                                                   input logic [CODE_W-1:0] order);
        logic [CNT_W-1:0] n;
        if (order == ORDER_LSB) begin
            n = CNT_W'(BYTE_W);
        end else begin
            unique case (len_code)
                2'd0:    n = CNT_W'(8);
                2'd1:    n = CNT_W'(12);
                default: n = CNT_W'(16);
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d[g];
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d[g]};
            end
        end
        assign q[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/sws_tx.sv
module sws_tx
    import sws_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                act,
    input  logic                fs_rise,
    input  logic [CODE_W-1:0]   cfg_len,
    input  logic [CODE_W-1:0]   cfg_order,
    input  logic                wr_en,
    input  logic [WORD_MAX-1:0] wr_data,
    output logic                pin,
    output logic                ready,
    output logic                event_o,
    output logic                underflow
);

    eng_state_t state_q, state_d;

    logic [WORD_MAX-1:0] hold_q, last_q, sh_q;
    logic                hold_full_q, pin_q, ev_q, uf_q, lsb_q;
    logic [CNT_W-1:0]    cnt_q, lim_q;

    logic                start, in_word, last_bit, load_lsb;
    logic [WORD_MAX-1:0] load_word;
    logic [CNT_W-1:0]    load_lim, align_amt;

    assign start     = (state_q == ENG_IDLE) && fs_rise;
    assign in_word   = (state_q == ENG_ARMED) || (state_q == ENG_SHIFT);
    assign last_bit  = (cnt_q == lim_q - CNT_W'(1));
    assign load_lim  = word_bits(cfg_len, cfg_order);
    assign load_lsb  = (cfg_order == ORDER_LSB);
    assign load_word = hold_full_q ? hold_q : last_q;
    assign align_amt = CNT_W'(WORD_MAX) - load_lim;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:  if (fs_rise)           state_d = ENG_ARMED;
            ENG_ARMED: if (act)               state_d = ENG_SHIFT;
            ENG_SHIFT: if (act && last_bit)   state_d = ENG_IDLE;
            default:                          state_d = ENG_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            last_q      <= '0;
            sh_q        <= '0;
            hold_full_q <= 1'b0;
            pin_q       <= 1'b0;
            ev_q        <= 1'b0;
            uf_q        <= 1'b0;
            lsb_q       <= 1'b0;
            cnt_q       <= '0;
            lim_q       <= CNT_W'(BYTE_W);
        end else begin
            ev_q <= 1'b0;
            if (start) begin
                lim_q <= load_lim;
                lsb_q <= load_lsb;
                cnt_q <= '0;
                // MSB-first words are left-aligned so bit WORD_MAX-1 leaves first
                sh_q  <= load_lsb ? load_word : (load_word << align_amt);
                if (hold_full_q) begin
                    last_q      <= hold_q;
                    hold_full_q <= 1'b0;
                    ev_q        <= !wr_en;
                end else begin
                    uf_q <= 1'b1;
                end
            end
            if (in_word && act) begin
                pin_q <= lsb_q ? sh_q[0] : sh_q[WORD_MAX-1];
                sh_q  <= lsb_q ? (sh_q >> 1) : (sh_q << 1);
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (wr_en) begin
                hold_q      <= wr_data;
                hold_full_q <= 1'b1;
                uf_q        <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        pin       = pin_q;
        ready     = !hold_full_q;
        event_o   = ev_q;
        underflow = uf_q;
    end

endmodule

// File: rtl/sws_rx.sv
module sws_rx
    import sws_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                act,
    input  logic                fs_rise,
    input  logic                din,
    input  logic [CODE_W-1:0]   cfg_len,
    input  logic [CODE_W-1:0]   cfg_order,
    input  logic                rd_en,
    output logic [WORD_MAX-1:0] rd_data,
    output logic                ready,
    output logic                event_o,
    output logic                overrun
);

    eng_state_t state_q, state_d;

    logic [WORD_MAX-1:0] sh_q, buf_q, rd_q;
    logic [CNT_W-1:0]    cnt_q, lim_q;
    logic                lsb_q, done_q, buf_full_q, rd_full_q, ev_q, ov_q;
    logic                start, in_word, last_bit, move;

    assign start    = (state_q == ENG_IDLE) && fs_rise;
    assign in_word  = (state_q == ENG_ARMED) || (state_q == ENG_SHIFT);
    assign last_bit = (cnt_q == lim_q - CNT_W'(1));
    assign move     = buf_full_q && !rd_full_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:  if (fs_rise)           state_d = ENG_ARMED;
            ENG_ARMED: if (act)               state_d = ENG_SHIFT;
            ENG_SHIFT: if (act && last_bit)   state_d = ENG_IDLE;
            default:                          state_d = ENG_IDLE;
        endcase
    end

    // shift register, cleared at frame start so narrow words come out zero-filled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            lim_q  <= CNT_W'(BYTE_W);
            lsb_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                sh_q  <= '0;
                cnt_q <= '0;
                lim_q <= word_bits(cfg_len, cfg_order);
                lsb_q <= (cfg_order == ORDER_LSB);
            end
            if (in_word && act) begin
                if (lsb_q) sh_q[BYTE_W-1:0] <= {din, sh_q[BYTE_W-1:1]};
                else       sh_q             <= {sh_q[WORD_MAX-2:0], din};
                cnt_q  <= cnt_q + CNT_W'(1);
                done_q <= last_bit;
            end
        end
    end

    // buffer and read register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q      <= '0;
            rd_q       <= '0;
            buf_full_q <= 1'b0;
            rd_full_q  <= 1'b0;
            ev_q       <= 1'b0;
            ov_q       <= 1'b0;
        end else begin
            ev_q <= 1'b0;
            if (move) begin
                rd_q       <= buf_q;
                rd_full_q  <= 1'b1;
                buf_full_q <= 1'b0;
                ev_q       <= 1'b1;
            end
            if (done_q) begin
                if (!buf_full_q || move) begin
                    buf_q      <= sh_q;
                    buf_full_q <= 1'b1;
                end else begin
                    ov_q <= 1'b1;
                end
            end
            if (rd_en && rd_full_q) begin
                rd_full_q <= 1'b0;
                ov_q      <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        rd_data = rd_q;
        ready   = rd_full_q;
        event_o = ev_q;
        overrun = ov_q;
    end

endmodule

// File: rtl/serial_word_shifter.sv
module serial_word_shifter
    import sws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_loop,
    input  logic                cfg_tx_pol,
    input  logic [CODE_W-1:0]   cfg_tx_len,
    input  logic [CODE_W-1:0]   cfg_tx_order,
    input  logic                cfg_rx_pol,
    input  logic [CODE_W-1:0]   cfg_rx_len,
    input  logic [CODE_W-1:0]   cfg_rx_order,
    input  logic                tx_bclk,
    input  logic                tx_fs,
    output logic                tx_pin,
    input  logic                rx_bclk,
    input  logic                rx_fs,
    input  logic                rx_pin,
    input  logic                wr_en,
    input  logic [WORD_MAX-1:0] wr_data,
    output logic                tx_ready,
    output logic                tx_event,
    output logic                tx_underflow,
    input  logic                rd_en,
    output logic [WORD_MAX-1:0] rd_data,
    output logic                rx_ready,
    output logic                rx_event,
    output logic                rx_overrun
);

    localparam int N_LINES = 5;
    localparam int N_EDGE  = 4;
    localparam int L_TXB = 0, L_TXF = 1, L_RXB = 2, L_RXF = 3, L_RXD = 4;

    logic [N_LINES-1:0] raw, lvl;
    logic [N_EDGE-1:0]  prev_q;

    logic tx_b_rise, tx_b_fall, tx_fs_rise;
    logic rx_b_rise, rx_b_fall, rx_fs_rise_ext;
    logic tx_act, rx_act, rx_fs_rise, rx_din;

    assign raw = {rx_pin, rx_fs, rx_bclk, tx_fs, tx_bclk};

    sws_sync #(
        .WIDTH  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl[N_EDGE-1:0];
    end

    always_comb begin
        tx_b_rise      =  lvl[L_TXB] & ~prev_q[L_TXB];
        tx_b_fall      = ~lvl[L_TXB] &  prev_q[L_TXB];
        tx_fs_rise     =  lvl[L_TXF] & ~prev_q[L_TXF];
        rx_b_rise      =  lvl[L_RXB] & ~prev_q[L_RXB];
        rx_b_fall      = ~lvl[L_RXB] &  prev_q[L_RXB];
        rx_fs_rise_ext =  lvl[L_RXF] & ~prev_q[L_RXF];

        tx_act = cfg_tx_pol ? tx_b_fall : tx_b_rise;
        if (cfg_loop) begin
            rx_act     = cfg_rx_pol ? tx_b_rise : tx_b_fall;
            rx_fs_rise = tx_fs_rise;
            rx_din     = tx_pin;
        end else begin
            rx_act     = cfg_rx_pol ? rx_b_rise : rx_b_fall;
            rx_fs_rise = rx_fs_rise_ext;
            rx_din     = lvl[L_RXD];
        end
    end

    sws_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (tx_act),
        .fs_rise   (tx_fs_rise),
        .cfg_len   (cfg_tx_len),
        .cfg_order (cfg_tx_order),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .pin       (tx_pin),
        .ready     (tx_ready),
        .event_o   (tx_event),
        .underflow (tx_underflow)
    );

    sws_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (rx_act),
        .fs_rise   (rx_fs_rise),
        .din       (rx_din),
        .cfg_len   (cfg_rx_len),
        .cfg_order (cfg_rx_order),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .ready     (rx_ready),
        .event_o   (rx_event),
        .overrun   (rx_overrun)
    );

endmodule

// File: rtl/sws_checker.sv
module sws_checker
    import sws_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic                tx_ready,
    input logic                tx_event,
    input logic                tx_underflow,
    input logic [WORD_MAX-1:0] rd_data,
    input logic                rx_ready,
    input logic                rx_event,
    input logic                rx_overrun
);

    p_tx_event_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_event |-> tx_ready);

    p_tx_event_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_event |=> !tx_event);

    p_rx_event_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> rx_ready);

    p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_en) |=> rx_ready);

    p_rd_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_en) |=> $stable(rd_data));

    p_rx_event_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> !rx_event);

    p_uf_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_underflow);

    p_ov_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rx_ready) |=> !rx_overrun);

endmodule

bind serial_word_shifter sws_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .tx_ready     (tx_ready),
    .tx_event     (tx_event),
    .tx_underflow (tx_underflow),
    .rd_data      (rd_data),
    .rx_ready     (rx_ready),
    .rx_event     (rx_event),
    .rx_overrun   (rx_overrun)
);

// File: tb/serial_word_shifter_tb.sv
module serial_word_shifter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 8;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_loop = 1'b0, cfg_tx_pol = 1'b0, cfg_rx_pol = 1'b0;
    logic [1:0]  cfg_tx_len = 2'd0, cfg_tx_order = 2'd0, cfg_rx_len = 2'd0, cfg_rx_order = 2'd0;
    logic        tx_bclk = 1'b0, tx_fs = 1'b0, rx_bclk = 1'b0, rx_fs = 1'b0, rx_pin = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        tx_pin, tx_ready, tx_event, tx_underflow, rx_ready, rx_event, rx_overrun;
    logic [15:0] rd_data;

    int n_chk = 0, n_fail = 0, tx_ev_cnt = 0, rx_ev_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_word_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_loop(cfg_loop),
        .cfg_tx_pol(cfg_tx_pol), .cfg_tx_len(cfg_tx_len), .cfg_tx_order(cfg_tx_order),
        .cfg_rx_pol(cfg_rx_pol), .cfg_rx_len(cfg_rx_len), .cfg_rx_order(cfg_rx_order),
        .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_pin(tx_pin),
        .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_pin(rx_pin),
        .wr_en(wr_en), .wr_data(wr_data), .tx_ready(tx_ready), .tx_event(tx_event),
        .tx_underflow(tx_underflow), .rd_en(rd_en), .rd_data(rd_data),
        .rx_ready(rx_ready), .rx_event(rx_event), .rx_overrun(rx_overrun)
    );

    always @(posedge clk) begin
        if (rst_n && tx_event) tx_ev_cnt <= tx_ev_cnt + 1;
        if (rst_n && rx_event) rx_ev_cnt <= rx_ev_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_tx(input logic pol, input logic [1:0] len, input logic [1:0] ord);
        cfg_tx_pol = pol; cfg_tx_len = len; cfg_tx_order = ord;
        tx_bclk = pol;
        tick(6);
    endtask

    task automatic set_rx(input logic pol, input logic [1:0] len, input logic [1:0] ord);
        cfg_rx_pol = pol; cfg_rx_len = len; cfg_rx_order = ord;
        rx_bclk = pol;
        tick(6);
    endtask

    task automatic write_word(input logic [15:0] w);
        wr_data = w; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
        tick(1);
    endtask

    task automatic read_word(output logic [15:0] w);
        w = rd_data; rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
        tick(3);
    endtask

    // one frame on the transmit side; bits are packed back by the order rule
    task automatic tx_frame(input int n, input logic lsb, output logic [15:0] w);
        logic [15:0] bits;
        bits = '0;
        tx_fs = 1'b1;
        tick(4);
        for (int i = 0; i < n; i++) begin
            tx_bclk = ~cfg_tx_pol;
            tick(HALF_BIT);
            if (i == 0) tx_fs = 1'b0;
            tx_bclk = cfg_tx_pol;
            tick(HALF_BIT);
            bits[i] = tx_pin;
        end
        w = '0;
        for (int i = 0; i < n; i++) begin
            if (lsb) w[i] = bits[i];
            else     w[n-1-i] = bits[i];
        end
        tick(8);
    endtask

    task automatic rx_frame(input logic [15:0] w, input int n, input logic lsb);
        rx_fs = 1'b1;
        tick(4);
        for (int i = 0; i < n; i++) begin
            rx_pin  = lsb ? w[i] : w[n-1-i];
            rx_bclk = ~cfg_rx_pol;
            tick(HALF_BIT);
            if (i == 0) rx_fs = 1'b0;
            rx_bclk = cfg_rx_pol;
            tick(HALF_BIT);
        end
        tick(8);
    endtask

    task automatic t_reset();
        chk("R10 tx_ready after reset", 32'(tx_ready), 32'd1);
        chk("R9 rx_ready after reset", 32'(rx_ready), 32'd0);
        chk("R7 tx_pin after reset", 32'(tx_pin), 32'd0);
        chk("R11 underflow after reset", 32'(tx_underflow), 32'd0);
        chk("R12 overrun after reset", 32'(rx_overrun), 32'd0);
    endtask

    task automatic t_tx_msb();
        logic [15:0] got;
        int ev0;
        set_tx(1'b0, 2'd0, 2'b00);
        write_word(16'h00A5);
        chk("R10 tx_ready low after write", 32'(tx_ready), 32'd0);
        ev0 = tx_ev_cnt;
        tx_frame(8, 1'b0, got);
        chk("R1 tx MSB-first 8-bit", 32'(got), 32'h00A5);
        chk("R10 one tx_event per load", 32'(tx_ev_cnt - ev0), 32'd1);
        chk("R10 tx_ready after load", 32'(tx_ready), 32'd1);
        for (int i = 0; i < 3; i++) begin
            tx_bclk = 1'b1; tick(HALF_BIT);
            tx_bclk = 1'b0; tick(HALF_BIT);
        end
        chk("R7 no frame sync, pin holds", 32'(tx_pin), 32'd1);
        set_tx(1'b0, 2'd0, 2'b10);
        write_word(16'h0035);
        tx_frame(8, 1'b0, got);
        chk("R1 order code 10 stays MSB-first", 32'(got), 32'h0035);
    endtask

    task automatic t_tx_len_pol();
        logic [15:0] got;
        set_tx(1'b0, 2'd1, 2'b00);
        write_word(16'h0ABC);
        tx_frame(12, 1'b0, got);
        chk("R2 tx 12-bit word", 32'(got), 32'h0ABC);
        set_tx(1'b1, 2'd2, 2'b00);
        write_word(16'h1234);
        tx_frame(16, 1'b0, got);
        chk("R6 tx 16-bit falling-edge polarity", 32'(got), 32'h1234);
    endtask

    task automatic t_tx_lsb();
        logic [15:0] got;
        set_tx(1'b0, 2'd0, 2'b01);
        write_word(16'h00C1);
        tx_frame(8, 1'b1, got);
        chk("R3 tx LSB-first 8-bit", 32'(got), 32'h00C1);
        set_tx(1'b0, 2'd2, 2'b01);
        write_word(16'hF0A5);
        tx_frame(8, 1'b1, got);
        chk("R5 tx forced 8-bit low byte", 32'(got), 32'h00A5);
        write_word(16'h005A);
        tx_frame(8, 1'b1, got);
        chk("R5 tx forced word ends after 8 bits", 32'(got), 32'h005A);
    endtask

    task automatic t_rx();
        logic [15:0] got;
        int ev0;
        set_rx(1'b1, 2'd2, 2'b00);
        ev0 = rx_ev_cnt;
        rx_frame(16'hBEEF, 16, 1'b0);
        chk("R9 rx_ready after word", 32'(rx_ready), 32'd1);
        chk("R9 one rx_event", 32'(rx_ev_cnt - ev0), 32'd1);
        read_word(got);
        chk("R6 rx 16-bit rising-edge polarity", 32'(got), 32'hBEEF);
        chk("R9 rx_ready cleared by read", 32'(rx_ready), 32'd0);
        set_rx(1'b0, 2'd1, 2'b00);
        rx_frame(16'h0ABC, 12, 1'b0);
        read_word(got);
        chk("R2 rx 12-bit right-justified", 32'(got), 32'h0ABC);
        set_rx(1'b0, 2'd0, 2'b00);
        rx_frame(16'h0096, 8, 1'b0);
        read_word(got);
        chk("R1 rx MSB-first 8-bit zero-filled", 32'(got), 32'h0096);
    endtask

    task automatic t_rx_lsb();
        logic [15:0] got;
        set_rx(1'b0, 2'd0, 2'b01);
        rx_frame(16'h002D, 8, 1'b1);
        read_word(got);
        chk("R4 rx LSB-first 8-bit", 32'(got), 32'h002D);
        set_rx(1'b0, 2'd1, 2'b01);
        rx_frame(16'h0081, 8, 1'b1);
        chk("R5 rx forced word done after 8 bits", 32'(rx_ready), 32'd1);
        read_word(got);
        chk("R5 rx forced 8-bit value", 32'(got), 32'h0081);
    endtask

    task automatic t_loop();
        logic [15:0] got, back;
        cfg_loop = 1'b1;
        rx_pin = 1'b1;
        set_tx(1'b0, 2'd1, 2'b00);
        set_rx(1'b0, 2'd1, 2'b00);
        write_word(16'h06C9);
        tx_frame(12, 1'b0, got);
        chk("R8 loopback word ready", 32'(rx_ready), 32'd1);
        read_word(back);
        chk("R8 loopback readback", 32'(back), 32'h06C9);
        cfg_loop = 1'b0;
        rx_pin = 1'b0;
        tick(4);
    endtask

    task automatic t_underflow();
        logic [15:0] got;
        int ev0;
        set_tx(1'b0, 2'd0, 2'b00);
        write_word(16'h003E);
        tx_frame(8, 1'b0, got);
        chk("R11 no underflow with data", 32'(tx_underflow), 32'd0);
        ev0 = tx_ev_cnt;
        tx_frame(8, 1'b0, got);
        chk("R11 previous word resent", 32'(got), 32'h003E);
        chk("R11 underflow set", 32'(tx_underflow), 32'd1);
        chk("R10 no tx_event on empty frame", 32'(tx_ev_cnt - ev0), 32'd0);
        write_word(16'h0011);
        chk("R11 write clears underflow", 32'(tx_underflow), 32'd0);
        tx_frame(8, 1'b0, got);
        chk("R11 new word after underflow", 32'(got), 32'h0011);
    endtask

    task automatic t_overrun();
        logic [15:0] got;
        set_rx(1'b0, 2'd0, 2'b00);
        rx_frame(16'h0011, 8, 1'b0);
        rx_frame(16'h0022, 8, 1'b0);
        chk("R12 no overrun with two held", 32'(rx_overrun), 32'd0);
        rx_frame(16'h0033, 8, 1'b0);
        chk("R12 overrun set on third word", 32'(rx_overrun), 32'd1);
        read_word(got);
        chk("R12 first word kept", 32'(got), 32'h0011);
        chk("R12 read clears overrun", 32'(rx_overrun), 32'd0);
        read_word(got);
        chk("R12 second word kept", 32'(got), 32'h0022);
        chk("R12 third word discarded", 32'(rx_ready), 32'd0);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_tx_msb();
        t_tx_len_pol();
        t_tx_lsb();
        t_rx();
        t_rx_lsb();
        t_loop();
        t_underflow();
        t_overrun();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule